// File: doc/BRIEF.md
# Free-Running Compare Timer

This block is a memory-mapped tick source. A 32-bit counter only ever moves upward. It advances once every prescaler period and keeps running when it reaches the compare value; it does not reload. Each time a count step lands the counter on the compare value, a sticky status flag is set. The interrupt line shows that flag, masked by an enable bit. Software makes periodic ticks by adding its period to the compare value after every event. Because the arithmetic is modulo 2^32, a tick scheduled past the wrap still works.

The register port is simple. It has a word address, write data and a write strobe, and the read data is combinational. Three other inputs affect counting:

- A clock-enable input freezes the counter and the prescaler.
- A debug-active input pauses counting when software has allowed it to.
- A reset-count control bit clears the counter. Software can poll the counter until it reads zero.

Top module: `matchTimer`

Register words (addr): 0 control, 1 interrupt enable, 2 prescale limit, 3 compare value, 4 counter (read-only), 5 status. All other words read as zero.

## Requirements
- R1: With prescale limit P (word 2), the counter rises by exactly one after every P+1 enabled clocks, counted from the clock edge that writes control with the run bit (bit 0) set.
- R2: A compare event neither reloads nor stops the counter. After 2^CntWidth-1 the counter continues at 0.
- R3: While control bit 1 (zero request) is set, the counter and the prescaler are held at zero. The counter reads 0 one clock after the write that sets the bit, and counting restarts from a fresh prescaler period.
- R4: Writing 0 to control stops counting. The counter keeps its value.
- R5: Control bit 2 (debug pause) makes counting halt while dbgActive is high. With bit 2 clear, dbgActive has no effect.
- R6: While clkEn is low, the counter and the prescaler keep their values. Counting resumes where it stopped.
- R7: Status bit 0 becomes 1 on any count step whose new counter value equals the compare value (word 3). This happens even when the interrupt enable is 0.
- R8: Writing a 1 to status bit 0 clears it. Writing 0 leaves it unchanged. A compare event in the same cycle takes priority over the clear.
- R9: irq is high exactly when status bit 0 and interrupt-enable bit 0 (word 1) are both 1.
- R10: The compare value may be rewritten at any time. The comparison uses the new value from the next count step on, so adding a period to the old value produces periodic events.
- R11: After reset every register and the counter read 0. Writes to the counter word have no effect, and unused words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Timer clock gate; low freezes counter and prescaler |
| dbgActive | input | 1 | Debugger halt indication |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wrData | input | DataWidth | Register write data |
| rdData | output | DataWidth | Read data for addr, combinational |
| irq | output | 1 | Masked compare interrupt |

## Verification
The assertions take every input to be synchronous to clk, and each write to last exactly one cycle with addr and wrData stable. They also assume that clkEn and dbgActive change only between edges, so the strobes seen at an edge match the values the checker samples. The bench keeps within these limits. It drives every input on the falling edge, holds each write for one full cycle, and reads on the falling edge. It never lowers the prescale limit below a running prescaler value.

// File: rtl/timerPkg.sv
package timerPkg;
  localparam int AddrWidth = 3;

  localparam logic [AddrWidth-1:0] RegCtrl      = 3'd0;
  localparam logic [AddrWidth-1:0] RegIrqEn     = 3'd1;
  localparam logic [AddrWidth-1:0] RegPresc     = 3'd2;
  localparam logic [AddrWidth-1:0] RegMatch     = 3'd3;
  localparam logic [AddrWidth-1:0] RegCount     = 3'd4;
  localparam logic [AddrWidth-1:0] RegStatus    = 3'd5;

  localparam int CtrlRunBit  = 0;
  localparam int CtrlZeroBit = 1;
  localparam int CtrlDbgBit  = 2;

  // strobes from control to datapath, valid for the coming edge
  typedef struct packed {
    logic step;   // timer clock enabled and allowed to count
    logic zero;   // clear counter and prescaler
  } dpStrobe_t;
endpackage

// File: rtl/tmrControl.sv
module tmrControl
  import timerPkg::*;
#(
  parameter int DataWidth = 32,
  parameter int PreWidth  = 32,
  parameter int CntWidth  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 dbgActive,
  input  logic                 wrEn,
  input  logic [AddrWidth-1:0] addr,
  input  logic [DataWidth-1:0] wrData,
  input  logic                 hit,
  input  logic [CntWidth-1:0]  cntVal,
  output dpStrobe_t            strobe,
  output logic [PreWidth-1:0]  prescVal,
  output logic [DataWidth-1:0] matchVal,
  output logic                 statFlag,
  output logic                 irqEn,
  output logic [DataWidth-1:0] rdData
);
  logic runEn, zeroEn, dbgEn;
  logic wrCtrl, wrIrqEn, wrPresc, wrMatch, wrStatus;

  always_comb begin
    wrCtrl   = wrEn && (addr == RegCtrl);
    wrIrqEn  = wrEn && (addr == RegIrqEn);
    wrPresc  = wrEn && (addr == RegPresc);
    wrMatch  = wrEn && (addr == RegMatch);
    wrStatus = wrEn && (addr == RegStatus);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      zeroEn   <= 1'b0;
      dbgEn    <= 1'b0;
      irqEn    <= 1'b0;
      prescVal <= '0;
      matchVal <= '0;
      statFlag <= 1'b0;
    end else begin
      if (wrCtrl) begin
        runEn  <= wrData[CtrlRunBit];
        zeroEn <= wrData[CtrlZeroBit];
        dbgEn  <= wrData[CtrlDbgBit];
      end
      if (wrIrqEn) irqEn    <= wrData[0];
      if (wrPresc) prescVal <= wrData[PreWidth-1:0];
      if (wrMatch) matchVal <= wrData;
      // a compare event outranks a simultaneous clear
      if (hit)                         statFlag <= 1'b1;
      else if (wrStatus && wrData[0])  statFlag <= 1'b0;
    end
  end

  always_comb begin
    strobe.zero = clkEn && zeroEn;
    strobe.step = clkEn && runEn && !zeroEn && !(dbgEn && dbgActive);
  end

  always_comb begin
    rdData = '0;
    unique case (addr)
      RegCtrl: begin
        rdData[CtrlRunBit]  = runEn;
        rdData[CtrlZeroBit] = zeroEn;
        rdData[CtrlDbgBit]  = dbgEn;
      end
      RegIrqEn:  rdData[0] = irqEn;
      RegPresc:  rdData    = DataWidth'(prescVal);
      RegMatch:  rdData    = matchVal;
      RegCount:  rdData    = DataWidth'(cntVal);
      RegStatus: rdData[0] = statFlag;
      default:   rdData    = '0;
    endcase
  end
endmodule

// File: rtl/tmrDatapath.sv
module tmrDatapath
  import timerPkg::*;
#(
  parameter int DataWidth = 32,
  parameter int PreWidth  = 32,
  parameter int CntWidth  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [PreWidth-1:0]  prescVal,
  input  logic [DataWidth-1:0] matchVal,
  output logic [CntWidth-1:0]  cntVal,
  output logic                 hit
);
  logic [PreWidth-1:0] preQ;
  logic [CntWidth-1:0] cntNext;
  logic                preDone;
  logic                advance;

  always_comb begin
    // >= keeps a lowered limit from running the prescaler through its full range
    preDone = (preQ >= prescVal);
    advance = strobe.step && preDone;
    cntNext = cntVal + CntWidth'(1);
    hit     = advance && (cntNext == matchVal[CntWidth-1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ   <= '0;
      cntVal <= '0;
    end else if (strobe.zero) begin
      preQ   <= '0;
      cntVal <= '0;
    end else if (strobe.step) begin
      if (preDone) begin
        preQ   <= '0;
        cntVal <= cntNext;
      end else begin
        preQ   <= preQ + PreWidth'(1);
      end
    end
  end
endmodule

// File: rtl/matchTimer.sv
module matchTimer
  import timerPkg::*;
#(
  parameter int DataWidth = 32,
  parameter int PreWidth  = 32,
  parameter int CntWidth  = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkEn,
  input  logic                 dbgActive,
  input  logic                 wrEn,
  input  logic [2:0]           addr,
  input  logic [DataWidth-1:0] wrData,
  output logic [DataWidth-1:0] rdData,
  output logic                 irq
);
  dpStrobe_t             strobeS;
  logic [PreWidth-1:0]   prescVal;
  logic [DataWidth-1:0]  matchVal;
  logic [CntWidth-1:0]   cntVal;
  logic                  hit;
  logic                  statFlag;
  logic                  irqEn;

  tmrControl #(.DataWidth(DataWidth), .PreWidth(PreWidth), .CntWidth(CntWidth)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .dbgActive(dbgActive),
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .hit(hit), .cntVal(cntVal),
    .strobe(strobeS), .prescVal(prescVal), .matchVal(matchVal),
    .statFlag(statFlag), .irqEn(irqEn), .rdData(rdData)
  );

  tmrDatapath #(.DataWidth(DataWidth), .PreWidth(PreWidth), .CntWidth(CntWidth)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobeS),
    .prescVal(prescVal), .matchVal(matchVal),
    .cntVal(cntVal), .hit(hit)
  );

  assign irq = statFlag && irqEn;
endmodule

// File: rtl/matchTimerChk.sv
module matchTimerChk
  import timerPkg::*;
#(
  parameter int DataWidth = 32,
  parameter int CntWidth  = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 clkEn,
  input logic                 wrEn,
  input logic [2:0]           addr,
  input logic [DataWidth-1:0] wrData,
  input dpStrobe_t            strobeS,
  input logic [CntWidth-1:0]  cntVal,
  input logic                 hit,
  input logic                 statFlag
);
  logic clearReq;
  assign clearReq = wrEn && (addr == RegStatus) && wrData[0];

  // R1 R2: the counter only moves by one step up, or to zero
  p_count_up_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cntVal != $past(cntVal)) |-> ((cntVal == $past(cntVal) + CntWidth'(1)) || (cntVal == '0)));

  // R3: a zero request clears the counter
  p_zero_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobeS.zero |=> (cntVal == '0));

  // R4 R5: no step and no zero request means the counter holds
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobeS.step && !strobeS.zero) |=> $stable(cntVal));

  // R6: gated clock freezes the counter
  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(cntVal));

  // R7: a compare event sets the flag
  p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rstN)
    hit |=> statFlag);

  // R8: the flag is sticky unless a one is written to it
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statFlag && !clearReq) |=> statFlag);

  // R8: a clear without a compare event drops the flag
  p_w1c_r8: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !hit) |=> !statFlag);
endmodule

bind matchTimer matchTimerChk #(.DataWidth(DataWidth), .CntWidth(CntWidth)) uChk (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .strobeS(strobeS), .cntVal(cntVal), .hit(hit), .statFlag(statFlag)
);

// File: tb/tb_matchTimer.sv
module tb_matchTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clkEn = 1'b1;
  logic        dbgActive = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataW;
  logic        irq, irqW;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  matchTimer dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .dbgActive(dbgActive),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // narrow counter, same bus, used to reach the wrap
  matchTimer #(.CntWidth(8)) dutW (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .dbgActive(dbgActive),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdDataW), .irq(irqW)
  );

  localparam logic [2:0] ACtrl = 3'd0, AIen = 3'd1, APre = 3'd2,
                         AMatch = 3'd3, ACnt = 3'd4, AStat = 3'd5;

  typedef struct packed {
    logic [31:0] presc;
    logic [31:0] match;
    logic [31:0] waitCyc;
    logic [31:0] ien;
    logic [31:0] expCnt;
    logic [31:0] expFlag;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{32'd0,  32'd5,   32'd10, 32'd1, 32'd10, 32'd1},
    '{32'd12, 32'd3,   32'd40, 32'd1, 32'd3,  32'd1},
    '{32'd12, 32'd4,   32'd40, 32'd1, 32'd3,  32'd0},
    '{32'd3,  32'd2,   32'd8,  32'd0, 32'd2,  32'd1},
    '{32'd1,  32'd100, 32'd50, 32'd1, 32'd25, 32'd0},
    '{32'd2,  32'd0,   32'd30, 32'd1, 32'd10, 32'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called on a falling edge; consumes exactly one rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic rdW(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdDataW;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    // R11 reset state
    rd(ACnt, v);  check("R11 count", v, 0);
    rd(AStat, v); check("R11 status", v, 0);
    rd(ACtrl, v); check("R11 ctrl", v, 0);
    check("R11 irq", {31'd0, irq}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R7 R9 table
    for (int i = 0; i < 6; i++) begin
      wr(ACtrl, 32'd2);
      wr(APre, VECS[i].presc);
      wr(AMatch, VECS[i].match);
      wr(AIen, VECS[i].ien);
      wr(AStat, 32'd1);
      wr(ACtrl, 32'd1);
      repeat (VECS[i].waitCyc) @(negedge clk);
      rd(ACnt, v);  check("R1 count", v, VECS[i].expCnt);
      rd(AStat, v); check("R7 flag", v, VECS[i].expFlag);
      check("R9 irq", {31'd0, irq}, VECS[i].expFlag & VECS[i].ien);
    end

    // R3 zero request while running
    wr(ACtrl, 32'd2);
    @(negedge clk);
    rd(ACnt, v); check("R3 zero", v, 0);
    repeat (5) @(negedge clk);
    rd(ACnt, v); check("R3 held", v, 0);

    // R4 stop
    wr(APre, 32'd0);
    wr(ACtrl, 32'd1);
    repeat (7) @(negedge clk);
    wr(ACtrl, 32'd0);
    rd(ACnt, v); check("R4 at stop", v, 8);
    repeat (10) @(negedge clk);
    rd(ACnt, v); check("R4 hold", v, 8);

    // R5 debug pause
    wr(ACtrl, 32'd2);
    wr(ACtrl, 32'd5);
    dbgActive = 1'b1;
    repeat (10) @(negedge clk);
    rd(ACnt, v); check("R5 paused", v, 0);
    dbgActive = 1'b0;
    repeat (4) @(negedge clk);
    rd(ACnt, v); check("R5 resumed", v, 4);
    wr(ACtrl, 32'd1);
    dbgActive = 1'b1;
    repeat (6) @(negedge clk);
    rd(ACnt, v); check("R5 no pause when disabled", v, 11);
    dbgActive = 1'b0;

    // R6 clock gate
    wr(ACtrl, 32'd2);
    wr(APre, 32'd3);
    wr(ACtrl, 32'd1);
    repeat (6) @(negedge clk);
    clkEn = 1'b0;
    repeat (20) @(negedge clk);
    rd(ACnt, v); check("R6 gated", v, 1);
    clkEn = 1'b1;
    repeat (6) @(negedge clk);
    rd(ACnt, v); check("R6 resumed", v, 3);

    // R8 write-one-to-clear
    wr(ACtrl, 32'd2);
    wr(APre, 32'd0);
    wr(AMatch, 32'd3);
    wr(AIen, 32'd1);
    wr(AStat, 32'd1);
    wr(ACtrl, 32'd1);
    repeat (3) @(negedge clk);
    rd(AStat, v); check("R7 flag set", v, 1);
    wr(ACtrl, 32'd0);
    wr(AStat, 32'd0);
    rd(AStat, v); check("R8 write zero", v, 1);
    wr(AStat, 32'd1);
    rd(AStat, v); check("R8 write one", v, 0);
    check("R9 irq low", {31'd0, irq}, 0);

    // R10 periodic advance of compare
    wr(AMatch, 32'd7);
    wr(ACtrl, 32'd1);
    repeat (2) @(negedge clk);
    rd(AStat, v); check("R10 before", v, 0);
    @(negedge clk);
    rd(AStat, v); check("R10 first", v, 1);
    wr(AStat, 32'd1);
    wr(AMatch, 32'd10);
    rd(AStat, v); check("R10 cleared", v, 0);
    @(negedge clk);
    rd(AStat, v); check("R10 second", v, 1);
    rd(ACnt, v); check("R10 count", v, 10);

    // R2 wrap on narrow instance
    wr(ACtrl, 32'd2);
    wr(APre, 32'd0);
    wr(AMatch, 32'd2);
    wr(AStat, 32'd1);
    wr(ACtrl, 32'd1);
    repeat (258) @(negedge clk);
    rd(ACnt, v);  check("R2 runs past compare", v, 258);
    rdW(ACnt, v); check("R2 wrap", v, 2);

    // R11 counter word read-only, unused word
    wr(ACtrl, 32'd0);
    rd(ACnt, v);
    wr(ACnt, 32'h0000_1234);
    rd(ACnt, v2); check("R11 count read-only", v2, v);
    rd(3'd6, v); check("R11 unused", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule